// File: doc/BRIEF.md
# Chained Serial Code Register for a Multi-Channel DAC

This block receives six-bit converter codes over a three-wire serial link (a serial clock, a data line and an active-low enable) and presents them as parallel codes, one per channel, to a resistor-ladder converter. All three pins are treated as slow asynchronous signals. A fast system clock samples them, passes them through synchronizer flops, and finds the serial clock's falling edges in logic. While the enable is asserted, each falling edge shifts one data bit into a chain register that holds six bits per channel. When the enable is released, the whole chain is copied into the output codes in a single cycle.

The far end of the chain is driven out as a serial data output, so several blocks can be cascaded with each output feeding the next block's data input. A host loads one word per channel, starting with the highest channel and ending with channel 1. The channel count is a parameter, from 1 to 6. A full load therefore takes six serial clocks per channel.

Top module: `dac_code_chain`

## Requirements
- R1: A synchronous active-high reset clears the chain register and every channel code to zero, so `ser_dat_o` reads 0 after reset.
- R2: While the synchronized enable is low, each falling edge of the synchronized serial clock moves the chain up by one bit, and the synchronized data bit enters at bit 0.
- R3: A rising edge of the serial clock never moves the chain, so `ser_dat_o` stays as it was until the next falling edge.
- R4: The channel codes change only on a low-to-high transition of the enable, and they take the entire chain in one cycle. While a load is in progress they keep their previous values.
- R5: Serial clock activity while the enable is high leaves the chain untouched. This includes a clock fall just before the enable is asserted. A later release with no clocks in between re-latches the same codes.
- R6: Words arrive most significant bit first. Channel 1 is the last word shifted in and appears on `ch_code_o[5:0]`. Channel k appears on `ch_code_o[6k-1:6k-6]`, so the first word of a full load lands on the highest channel.
- R7: `ser_dat_o` is the top bit of the chain, which is the bit shifted in 6×NUM_CH falling edges earlier. Surplus clocks therefore pass older words on to a following device.
- R8: A load with fewer than 6×NUM_CH clocks still copies the whole chain. Upper channels receive the older bits that were moved up into them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples the serial pins |
| rst | input | 1 | Synchronous reset, active high |
| ser_clk_i | input | 1 | Serial clock; data are taken on its falling edge |
| ser_dat_i | input | 1 | Serial data in |
| ser_en_n_i | input | 1 | Load enable, active low; its release latches the codes |
| ser_dat_o | output | 1 | Far end of the chain, for cascading |
| ch_code_o | output | 6×NUM_CH | Latched codes; channel 1 in the low six bits |

## Verification
The loads use codes that differ per channel (ascending values, all ones, alternating bit patterns, all zeros). These expose any swap of channel order or bit order, and any stuck or bridged bit. The chain tail is observed after every rising and every falling serial clock edge. This separates shifting on the correct edge from shifting on both edges. Clock toggles with the enable high, a release with no clocks, a two-word short load and a seven-word overlong load each separate gating, partial-load carry-over and cascade pass-through from a plain full load.

// File: rtl/dcc_pkg.sv
`timescale 1ns/1ps
package dcc_pkg;
    localparam int unsigned CODE_W = 6;
    localparam int unsigned MAX_CH = 6;

    typedef struct packed {
        logic sclk;
        logic sdat;
        logic en_n;
    } pin_t;

    localparam pin_t PIN_RST = '{sclk: 1'b0, sdat: 1'b0, en_n: 1'b1};

    typedef struct packed {
        logic sclk_prev;
        logic en_prev;
    } edge_st_t;
endpackage

// File: rtl/dcc_sync.sv
`timescale 1ns/1ps
module dcc_sync #(
    parameter int unsigned W       = 3,
    parameter int unsigned STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_i;
        for (int s = 1; s < int'(STAGES); s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= chain_d;
        end
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/dcc_edge.sv
`timescale 1ns/1ps
module dcc_edge
    import dcc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  pin_t pins_s,
    output logic shift_o,
    output logic bit_o,
    output logic load_o
);
    edge_st_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.sclk_prev = pins_s.sclk;
        st_d.en_prev   = pins_s.en_n;
        // a fall is accepted only while the enable is active in this cycle
        shift_o = !pins_s.en_n && st_q.sclk_prev && !pins_s.sclk;
        load_o  = pins_s.en_n && !st_q.en_prev;
        bit_o   = pins_s.sdat;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{sclk_prev: 1'b0, en_prev: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/dcc_shifter.sv
`timescale 1ns/1ps
module dcc_shifter #(
    parameter int unsigned TOT = 36
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           shift_i,
    input  logic           bit_i,
    output logic [TOT-1:0] sr_o
);
    logic [TOT-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (shift_i) begin
            sr_d = {sr_q[TOT-2:0], bit_i};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= '0;
        end else begin
            sr_q <= sr_d;
        end
    end

    assign sr_o = sr_q;
endmodule

// File: rtl/dcc_latch.sv
`timescale 1ns/1ps
module dcc_latch
    import dcc_pkg::*;
#(
    parameter int unsigned NUM_CH = 6,
    localparam int unsigned TOT   = NUM_CH * CODE_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load_i,
    input  logic [TOT-1:0] sr_i,
    output logic [TOT-1:0] codes_o
);
    logic [NUM_CH-1:0][CODE_W-1:0] code_d, code_q;

    always_comb begin
        for (int ch = 0; ch < int'(NUM_CH); ch++) begin
            code_d[ch] = load_i ? sr_i[ch*CODE_W +: CODE_W] : code_q[ch];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= '0;
        end else begin
            code_q <= code_d;
        end
    end

    for (genvar g = 0; g < int'(NUM_CH); g++) begin : g_out
        assign codes_o[g*CODE_W +: CODE_W] = code_q[g];
    end
endmodule

// File: rtl/dac_code_chain.sv
`timescale 1ns/1ps
module dac_code_chain
    import dcc_pkg::*;
#(
    parameter int unsigned NUM_CH      = 6,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned TOT_BITS   = NUM_CH * CODE_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ser_clk_i,
    input  logic                ser_dat_i,
    input  logic                ser_en_n_i,
    output logic                ser_dat_o,
    output logic [TOT_BITS-1:0] ch_code_o
);
    pin_t pins_a, pins_s;
    logic sclk_s, dat_s, en_n_s;
    logic shift, shift_bit, load;
    logic [TOT_BITS-1:0] sr;

    assign pins_a = '{sclk: ser_clk_i, sdat: ser_dat_i, en_n: ser_en_n_i};

    dcc_sync #(
        .W      ($bits(pin_t)),
        .STAGES (SYNC_STAGES),
        .RST_VAL(PIN_RST)
    ) u_sync (
        .clk    (clk),
        .rst    (rst),
        .async_i(pins_a),
        .sync_o (pins_s)
    );

    assign sclk_s = pins_s.sclk;
    assign dat_s  = pins_s.sdat;
    assign en_n_s = pins_s.en_n;

    dcc_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .pins_s (pins_s),
        .shift_o(shift),
        .bit_o  (shift_bit),
        .load_o (load)
    );

    dcc_shifter #(.TOT(TOT_BITS)) u_shift (
        .clk    (clk),
        .rst    (rst),
        .shift_i(shift),
        .bit_i  (shift_bit),
        .sr_o   (sr)
    );

    dcc_latch #(.NUM_CH(NUM_CH)) u_latch (
        .clk    (clk),
        .rst    (rst),
        .load_i (load),
        .sr_i   (sr),
        .codes_o(ch_code_o)
    );

    assign ser_dat_o = sr[TOT_BITS-1];
endmodule

// File: rtl/dcc_checks.sv
`timescale 1ns/1ps
module dcc_checks #(
    parameter int unsigned TOT = 36
) (
    input logic           clk,
    input logic           rst,
    input logic           sclk_s,
    input logic           dat_s,
    input logic           en_n_s,
    input logic           shift,
    input logic           load,
    input logic [TOT-1:0] sr,
    input logic [TOT-1:0] ch_code_o,
    input logic           ser_dat_o
);
    AST_RESET_CLEAR: assert property (@(posedge clk)
        $past(rst) |-> (ch_code_o == '0 && !ser_dat_o)); // R1

    AST_MSB_FIRST: assert property (@(posedge clk) disable iff (rst)
        shift |=> (sr[0] == $past(dat_s) && sr[TOT-1:1] == $past(sr[TOT-2:0]))); // R2

    AST_FALL_ONLY: assert property (@(posedge clk) disable iff (rst)
        shift |-> (!sclk_s && $past(sclk_s) && !en_n_s)); // R3

    AST_LOAD_COPY: assert property (@(posedge clk) disable iff (rst)
        load |=> (ch_code_o == $past(sr))); // R4

    AST_CODE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(ch_code_o)); // R4

    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        en_n_s |=> $stable(sr)); // R5

    AST_TAIL_OUT: assert property (@(posedge clk) disable iff (rst)
        shift |=> (ser_dat_o == $past(sr[TOT-2]))); // R7
endmodule

bind dac_code_chain dcc_checks #(.TOT(TOT_BITS)) u_checks (
    .clk      (clk),
    .rst      (rst),
    .sclk_s   (sclk_s),
    .dat_s    (dat_s),
    .en_n_s   (en_n_s),
    .shift    (shift),
    .load     (load),
    .sr       (sr),
    .ch_code_o(ch_code_o),
    .ser_dat_o(ser_dat_o)
);

// File: tb/test_dac_code_chain.sv
`timescale 1ns/1ps
module test_dac_code_chain;
    localparam int NCH = 6;
    localparam int TOT = NCH * 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b0;
    logic sdat = 1'b0;
    logic sen_n = 1'b1;
    logic sdo;
    logic [TOT-1:0] codes;

    always #2.5 clk = ~clk;

    dac_code_chain #(.NUM_CH(NCH)) i_dac_code_chain (
        .clk       (clk),
        .rst       (rst),
        .ser_clk_i (sclk),
        .ser_dat_i (sdat),
        .ser_en_n_i(sen_n),
        .ser_dat_o (sdo),
        .ch_code_o (codes)
    );

    int n_checks = 0;
    int n_fail = 0;
    logic [TOT-1:0] model = '0;
    logic [TOT-1:0] latched = '0;
    logic [TOT-1:0] exp_q[$];
    string tag_q[$];
    event released;

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, logic [TOT-1:0] act, logic [TOT-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_tail(string req);
        chk(req, {{(TOT-1){1'b0}}, sdo}, {{(TOT-1){1'b0}}, model[TOT-1]});
    endtask

    task automatic send_bit(logic b);
        sdat = b;
        wait_clk(2);
        sclk = 1'b1;
        wait_clk(5);
        chk_tail("R3 rising edge must not shift");
        sclk = 1'b0;
        model = {model[TOT-2:0], b};
        wait_clk(5);
        chk_tail("R7 tail after falling edge");
    endtask

    task automatic send_word(logic [5:0] w);
        for (int i = 5; i >= 0; i--) send_bit(w[i]);
    endtask

    task automatic open_load();
        sen_n = 1'b0;
        wait_clk(4);
    endtask

    task automatic close_load(string tag);
        sen_n = 1'b1;
        exp_q.push_back(model);
        tag_q.push_back(tag);
        latched = model;
        ->released;
        wait_clk(8);
    endtask

    // monitor: compares the latched codes after each release
    initial begin
        forever begin
            @(released);
            wait_clk(6);
            begin
                logic [TOT-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(t, codes, e);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        wait_clk(5);
        rst = 1'b0;
        wait_clk(3);
        chk("R1 codes after reset", codes, '0);
        chk_tail("R1 tail after reset");

        // ascending codes, channel 6 first
        open_load();
        for (int c = NCH; c >= 1; c--) send_word(6'(c));
        close_load("R2 R6 ascending codes");
        chk("R6 channel 1 slice", {{(TOT-6){1'b0}}, codes[5:0]}, {{(TOT-6){1'b0}}, 6'h01});
        chk("R6 channel 6 slice", {{(TOT-6){1'b0}}, codes[TOT-1 -: 6]}, {{(TOT-6){1'b0}}, 6'h06});

        // all ones, with a mid-load hold check
        open_load();
        for (int c = 0; c < 3; c++) send_word(6'h3F);
        chk("R4 codes held during load", codes, latched);
        for (int c = 0; c < NCH - 3; c++) send_word(6'h3F);
        chk("R4 codes held before release", codes, latched);
        close_load("R4 all ones");

        // alternating patterns
        open_load();
        for (int c = 0; c < NCH; c++) send_word(c[0] ? 6'h15 : 6'h2A);
        close_load("R2 R6 alternating");

        // clock activity with enable high, then a fall right before enable
        for (int k = 0; k < 8; k++) begin
            sdat = k[0];
            sclk = ~sclk;
            wait_clk(4);
        end
        sclk = 1'b1;
        wait_clk(5);
        sclk = 1'b0;
        wait_clk(1);
        open_load();
        wait_clk(4);
        chk_tail("R5 tail unchanged by gated clock");
        close_load("R5 release with no clocks keeps codes");

        // short load of two words
        open_load();
        send_word(6'h11);
        send_word(6'h22);
        close_load("R8 partial load");

        // overlong load: one word passes out of the tail
        open_load();
        for (int c = 0; c <= NCH; c++) send_word(6'(6'h30 + c));
        close_load("R7 overlong load");

        // all zeros
        open_load();
        for (int c = 0; c < NCH; c++) send_word(6'h00);
        close_load("R2 all zeros");

        wait_clk(10);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule